// File: doc/BRIEF.md
# Delay Line Calibrator by Ring Frequency Halving

This block tunes the binary-weighted code of a programmable delay line so that the line's delay matches the delay of a chosen critical path. It drives the multiplexers of an on-chip loop, which is assumed to be built from the critical-path cells and the delay line, so that the loop runs as a ring oscillator. It then measures the ring frequency by counting the ring's rising edges over a fixed window of reference clock cycles.

A calibration runs in three steps. First the ring closes around the critical path alone and the path-only count is taken. If that count is zero, the extra inversion stage is switched in and the count is taken once more. Next the delay line is switched into the ring with a zero code and measured again. Last, a bit-by-bit search from the most significant bit finds the largest code whose ring count is still at least half the path-only count. At that code the combined loop runs at half the path-only frequency, so the delay line adds one path delay. The result is written to a retained register that a first-fail monitor reads. A one-cycle done pulse marks the end of the calibration.

Top module: `ring_delay_cal`

## Requirements
- R1: While rst_ni is low, the outputs are: loop_close_o=0, dl_bypass_o=1, loop_invert_o=0, dl_code_o=0, cal_code_o=0 and done_o=0.
- R2: start_i sampled high while idle starts a calibration. From the next cycle on, loop_close_o=1, dl_bypass_o=1, loop_invert_o=0 and dl_code_o=0.
- R3: ring_i passes through a two-stage synchronizer, and a rising edge is counted when the second stage is 1 and the stage after it is 0. Each measurement counts over WIN_CYCLES reference cycles and takes WIN_CYCLES+2 cycles from its request to the next decision. A full calibration therefore lasts 11 or 12 measurements, counted from the start edge to the done edge.
- R4: If the path-only count is zero while loop_invert_o=0, loop_invert_o goes to 1 and the path-only count is taken once more. It is not retried after that, and it stays 1 until the next start.
- R5: After the path-only step, dl_bypass_o goes to 0 with dl_code_o=0 and one measurement is taken.
- R6: The search visits code bits 8 down to 0. Each trial sets the visited bit on top of the bits already kept. The bit is kept when the count is at least floor(path_count/2). A ring that never toggles therefore yields 9'h1FF.
- R7: done_o is high for exactly one cycle. In that same cycle cal_code_o takes the final code, loop_close_o=0 and dl_bypass_o=1.
- R8: cal_code_o changes only when done_o is high. start_i during a calibration is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; sets the measurement window |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Requests a calibration when idle |
| ring_i | input | 1 | Ring oscillator output, asynchronous |
| loop_close_o | output | 1 | Closes the oscillation loop |
| dl_bypass_o | output | 1 | Routes the loop around the delay line |
| loop_invert_o | output | 1 | Inserts the extra inversion stage |
| dl_code_o | output | CODE_W | Delay line code under trial |
| cal_code_o | output | CODE_W | Retained calibrated code |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench drives a modelled ring whose half period follows the selects and the code, and it predicts every output on every cycle. It covers a ring that oscillates without the extra inversion, one that needs the inversion (a design that failed to retry would search against a zero target and return all ones), and a ring that never toggles, which has to settle on all ones with the inversion left on. A start pulse in the middle of a calibration and a check of the retained code during the next run catch a controller that restarts or that overwrites cal_code_o early. The cycle count from start to done exposes an off-by-one window or a missing synchronizer stage.

// File: rtl/ring_cal_pkg.sv
package ring_cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PATH,
    ST_ZERO,
    ST_SRCH
  } cal_state_e;

  typedef struct packed {
    logic close;
    logic bypass;
    logic invert;
  } loop_sel_t;

  localparam loop_sel_t SEL_IDLE = '{close: 1'b0, bypass: 1'b1, invert: 1'b0};
endpackage

// File: rtl/ring_edge_sync.sv
module ring_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // stages [0..SYNC_STAGES-1] synchronize, last one holds the previous sample
  logic [SYNC_STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[SYNC_STAGES-1:0], async_i};
  end

  assign rise_o = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];
endmodule

// File: rtl/ring_window_counter.sv
module ring_window_counter #(
  parameter int WIN_CYCLES = 4096,
  parameter int CNT_W      = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             rise_i,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int TMR_W = $clog2(WIN_CYCLES);

  logic             busy_q;
  logic [TMR_W-1:0] tmr_q;
  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] acc_nx;

  assign acc_nx = acc_q + CNT_W'(rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      tmr_q   <= '0;
      acc_q   <= '0;
      done_o  <= 1'b0;
      count_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        busy_q <= 1'b1;
        tmr_q  <= '0;
        acc_q  <= '0;
      end else if (busy_q) begin
        acc_q <= acc_nx;
        tmr_q <= tmr_q + 1'b1;
        if (tmr_q == TMR_W'(WIN_CYCLES - 1)) begin
          busy_q  <= 1'b0;
          done_o  <= 1'b1;
          count_o <= acc_nx;
        end
      end
    end
  end
endmodule

// File: rtl/ring_cal_ctrl.sv
module ring_cal_ctrl
  import ring_cal_pkg::*;
#(
  parameter int CODE_W = 9,
  parameter int CNT_W  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              meas_done_i,
  input  logic [CNT_W-1:0]  meas_cnt_i,
  output logic              meas_go_o,
  output loop_sel_t         sel_o,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] stored_o,
  output logic              done_o
);
  localparam int BIT_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;

  cal_state_e        st_q;
  logic [CNT_W-1:0]  target_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CODE_W-1:0] bit_mask;
  logic [CODE_W-1:0] next_code;
  logic              keep;

  assign bit_mask  = CODE_W'(1) << bit_q;
  assign keep      = meas_cnt_i >= target_q;
  assign next_code = keep ? code_o : (code_o & ~bit_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sel_o     <= SEL_IDLE;
      code_o    <= '0;
      stored_o  <= '0;
      done_o    <= 1'b0;
      meas_go_o <= 1'b0;
      target_q  <= '0;
      bit_q     <= '0;
    end else begin
      meas_go_o <= 1'b0;
      done_o    <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q      <= ST_PATH;
          sel_o     <= '{close: 1'b1, bypass: 1'b1, invert: 1'b0};
          code_o    <= '0;
          meas_go_o <= 1'b1;
        end
        ST_PATH: if (meas_done_i) begin
          if (meas_cnt_i == '0 && !sel_o.invert) begin
            sel_o.invert <= 1'b1;
            meas_go_o    <= 1'b1;
          end else begin
            target_q     <= meas_cnt_i >> 1;
            sel_o.bypass <= 1'b0;
            st_q         <= ST_ZERO;
            meas_go_o    <= 1'b1;
          end
        end
        ST_ZERO: if (meas_done_i) begin
          st_q      <= ST_SRCH;
          bit_q     <= BIT_W'(CODE_W - 1);
          code_o    <= CODE_W'(1) << (CODE_W - 1);
          meas_go_o <= 1'b1;
        end
        ST_SRCH: if (meas_done_i) begin
          if (bit_q == '0) begin
            code_o       <= next_code;
            stored_o     <= next_code;
            done_o       <= 1'b1;
            sel_o.close  <= 1'b0;
            sel_o.bypass <= 1'b1;
            st_q         <= ST_IDLE;
          end else begin
            code_o    <= next_code | (bit_mask >> 1);
            bit_q     <= bit_q - 1'b1;
            meas_go_o <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_delay_cal.sv
module ring_delay_cal
  import ring_cal_pkg::*;
#(
  parameter int CODE_W      = 9,
  parameter int WIN_CYCLES  = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ring_i,
  output logic              loop_close_o,
  output logic              dl_bypass_o,
  output logic              loop_invert_o,
  output logic [CODE_W-1:0] dl_code_o,
  output logic [CODE_W-1:0] cal_code_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(WIN_CYCLES) + 1;

  logic             rise;
  logic             meas_go;
  logic             meas_done;
  logic [CNT_W-1:0] meas_cnt;
  loop_sel_t        sel;

  ring_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ring_i),
    .rise_o (rise)
  );

  ring_window_counter #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (meas_go),
    .rise_i (rise),
    .done_o (meas_done),
    .count_o(meas_cnt)
  );

  ring_cal_ctrl #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .meas_done_i(meas_done),
    .meas_cnt_i (meas_cnt),
    .meas_go_o  (meas_go),
    .sel_o      (sel),
    .code_o     (dl_code_o),
    .stored_o   (cal_code_o),
    .done_o     (done_o)
  );

  assign loop_close_o  = sel.close;
  assign dl_bypass_o   = sel.bypass;
  assign loop_invert_o = sel.invert;
endmodule

// File: rtl/ring_delay_cal_chk.sv
module ring_delay_cal_chk #(
  parameter int CODE_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              loop_close_i,
  input logic              dl_bypass_i,
  input logic              loop_invert_i,
  input logic [CODE_W-1:0] dl_code_i,
  input logic [CODE_W-1:0] cal_code_i,
  input logic              done_i
);
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r7_loop_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (!loop_close_i && dl_bypass_i));

  a_r8_stored_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(cal_code_i));

  a_r2_fresh_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loop_close_i) |-> (dl_bypass_i && !loop_invert_i && dl_code_i == '0));

  a_r4_invert_in_path_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loop_invert_i) |-> (loop_close_i && dl_bypass_i && dl_code_i == '0));

  a_r5_zero_code_on_insert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_close_i && $fell(dl_bypass_i)) |-> dl_code_i == '0);
endmodule

bind ring_delay_cal ring_delay_cal_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .loop_close_i (loop_close_o),
  .dl_bypass_i  (dl_bypass_o),
  .loop_invert_i(loop_invert_o),
  .dl_code_i    (dl_code_o),
  .cal_code_i   (cal_code_o),
  .done_i       (done_o)
);

// File: tb/ring_delay_cal_test.sv
`timescale 1ns/1ps
module ring_delay_cal_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 1024;
  localparam int CW         = 9;
  localparam int MEAS_LEN   = WIN + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          ring = 1'b0;
  logic          close_o, bypass_o, invert_o, done_o;
  logic [CW-1:0] code_o, stored_o;

  int checks = 0;
  int errors = 0;

  // ring oscillator stand-in
  int path_half = 20;
  bit need_inv  = 1'b0;
  bit dead      = 1'b0;
  int ph        = 0;

  // reference model state
  logic          e_close = 1'b0, e_bypass = 1'b1, e_inv = 1'b0, e_done = 1'b0;
  logic [CW-1:0] e_code = '0, e_stored = '0;
  logic [2:0]    hist = '0;

  ring_delay_cal #(.CODE_W(CW), .WIN_CYCLES(WIN)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .ring_i       (ring),
    .loop_close_o (close_o),
    .dl_bypass_o  (bypass_o),
    .loop_invert_o(invert_o),
    .dl_code_o    (code_o),
    .cal_code_o   (stored_o),
    .done_o       (done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!dead && close_o && (invert_o == need_inv)) begin
      ph = ph + 1;
      if (ph >= path_half + (bypass_o ? 0 : int'(code_o))) begin
        ring <= ~ring;
        ph = 0;
      end
    end else begin
      ring <= 1'b0;
      ph = 0;
    end
  end

  always @(posedge clk) hist <= {hist[1:0], ring};

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic meas(output int c);
    c = 0;
    @(posedge clk);
    repeat (WIN) begin
      @(posedge clk);
      c += int'(hist[1] & ~hist[2]);
    end
    @(posedge clk);
  endtask

  initial begin : model
    int c, tgt, cd;
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      e_done <= 1'b0;
      if (start) begin
        e_close <= 1'b1; e_bypass <= 1'b1; e_inv <= 1'b0; e_code <= '0;
        meas(c);
        if (c == 0) begin
          e_inv <= 1'b1;
          meas(c);
        end
        tgt = c / 2;
        e_bypass <= 1'b0;
        meas(c);
        cd = 1 << (CW - 1);
        e_code <= CW'(cd);
        for (int b = CW - 1; b >= 0; b--) begin
          meas(c);
          if (c < tgt) cd = cd & ~(1 << b);
          if (b > 0) begin
            cd = cd | (1 << (b - 1));
            e_code <= CW'(cd);
          end
        end
        e_code <= CW'(cd); e_stored <= CW'(cd);
        e_done <= 1'b1; e_close <= 1'b0; e_bypass <= 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk({close_o, bypass_o, invert_o} == {e_close, e_bypass, e_inv}, "R5", "loop selects",
          int'({close_o, bypass_o, invert_o}), int'({e_close, e_bypass, e_inv}));
      chk(code_o == e_code, "R6", "trial code", int'(code_o), int'(e_code));
      chk(done_o == e_done, "R7", "done pulse", int'(done_o), int'(e_done));
      chk(stored_o == e_stored, "R8", "stored code", int'(stored_o), int'(e_stored));
    end
  end

  task automatic run_cal(input int half, input bit ni, input bit dd, input bit poke,
                         input int prev, output int n);
    path_half = half; need_inv = ni; dead = dd;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(close_o && bypass_o && !invert_o && code_o == '0, "R2", "path step selects",
        int'({close_o, bypass_o, invert_o, code_o}), int'({3'b110, 9'd0}));
    n = 0;
    while (!done_o && n < 20000) begin
      @(negedge clk);
      n++;
      if (poke && n == 1500) begin
        start = 1'b1;
        @(negedge clk);
        n++;
        start = 1'b0;
        chk(int'(stored_o) == prev, "R8", "stored during run", int'(stored_o), prev);
      end
    end
    chk(done_o, "R7", "done reached", int'(done_o), 1);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int n, prev;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(!close_o && bypass_o && !invert_o, "R1", "reset selects",
        int'({close_o, bypass_o, invert_o}), 3'b010);
    chk(code_o == '0 && stored_o == '0, "R1", "reset codes", int'(code_o), 0);
    chk(!done_o, "R1", "reset done", int'(done_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // ring oscillates without inversion
    run_cal(20, 1'b0, 1'b0, 1'b0, 0, n);
    chk(n == 11 * MEAS_LEN, "R3", "calibration length, no inversion", n, 11 * MEAS_LEN);
    chk(!invert_o, "R4", "inversion left off", int'(invert_o), 0);
    chk(int'(stored_o) >= 16 && int'(stored_o) <= 24, "R6", "code near path delay",
        int'(stored_o), 20);

    // ring needs the extra inversion
    run_cal(12, 1'b1, 1'b0, 1'b0, 0, n);
    chk(n == 12 * MEAS_LEN, "R3", "calibration length, with inversion", n, 12 * MEAS_LEN);
    chk(invert_o, "R4", "inversion enabled", int'(invert_o), 1);
    chk(int'(stored_o) >= 8 && int'(stored_o) <= 16, "R6", "code near short path",
        int'(stored_o), 12);
    prev = int'(stored_o);

    // ring never toggles, mid-run start is ignored
    run_cal(20, 1'b0, 1'b1, 1'b1, prev, n);
    chk(n == 12 * MEAS_LEN, "R8", "mid-run start ignored", n, 12 * MEAS_LEN);
    chk(stored_o == 9'h1FF, "R6", "dead ring gives all ones", int'(stored_o), 9'h1FF);
    chk(invert_o, "R4", "inversion kept after retry", int'(invert_o), 1);
    @(negedge clk);
    chk(!done_o && stored_o == 9'h1FF, "R7", "done single cycle, code held",
        int'({done_o, stored_o}), 9'h1FF);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule